// File: doc/BRIEF.md
# GPIO Interrupt Line Selector

This block takes a wide bank of general-purpose input pins and turns a chosen few of them into interrupt requests. It has eight interrupt outputs. Each output watches one pin, and software chooses that pin by writing a 7-bit index. Software also chooses how each output reacts: to the pin's level, to one kind of edge, or to any change. A single global enable bit gates every output at once.

Software programs the block through a small word-addressed register bus. One control word holds the enable and the per-line trigger bits. Four selector words each hold the pin indices of two neighbouring lines. Reads are combinational from the address. A write takes effect at the clock edge where `bus_we` is sampled high.

Every pin passes through a two-stage synchronizer before it is used. A third stage keeps the previous synchronized sample, and edges are found by comparing the two. The decision for each line is registered before it reaches the output.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset every configuration field is zero, every register reads zero, and `irq_o` is all low.
- R2: The word at byte offset 0x00 is the control word. Bit 31 is the global enable. Bits 23:16 are the any-change enables for lines 7..0. Bits 15:8 select edge rather than level for lines 7..0. Bits 7:0 are the polarity bits for lines 7..0. Bits 30:24 read zero and ignore writes.
- R3: Line n takes its pin index from the selector word at byte offset 0x04 + 4*(n/2). An even line uses bits 6:0 and an odd line uses bits 16:22. All other bits of a selector word read zero and ignore writes.
- R4: Any offset with bits 1:0 not zero, and any word offset above 0x10, reads as zero and ignores writes.
- R5: Drive a pin change before rising clock edge k. Its effect appears on `irq_o` after edge k+2. This covers the two synchronizer flops and the output register.
- R6: In level mode (edge bit 0, any-change bit 0), the line follows the synchronized pin when its polarity bit is 0. It follows the inverted pin when its polarity bit is 1.
- R7: In single-edge mode (edge bit 1, any-change bit 0), the line gives a one-cycle pulse. It fires on a 0-to-1 transition when polarity is 0 and on a 1-to-0 transition when polarity is 1.
- R8: When a line's any-change bit is 1, the line pulses for each cycle in which the synchronized pin differs from its previous sample. The edge and polarity bits of that line have no effect.
- R9: A pin index from 62 to 127 never raises its line, in any mode and with any polarity.
- R10: While the global enable is 0, every output is low. A write that clears the enable forces all outputs low from the second rising edge after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| pins_i | input | 62 | Asynchronous GPIO inputs |
| irq_o | output | 8 | One interrupt output per line |

## Verification
Two things can happen in the same cycle: a register write that changes a line's selector, mode or global enable, and a transition on the pin that line is watching. The bench sets these up with random pin toggles and random writes to every selector word and to the control word. Some writes deliberately land on cycles where the watched pins change. Each result is compared against a cycle-accurate reference. In that reference, the write only affects decisions made from the edge after the one that stores it, so a pulse raised under the old configuration is still expected.

// File: rtl/girq_pkg.sv
package girq_pkg;
    localparam int LINES     = 8;
    localparam int IDX_W     = 7;
    localparam int PINS      = 62;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 8;
    localparam int SEL_WORDS = LINES / 2;

    localparam int EN_BIT    = 31;
    localparam int ANY_LSB   = 16;
    localparam int EDGE_LSB  = 8;
    localparam int POL_LSB   = 0;
    localparam int ODD_LSB   = 16;

    typedef struct packed {
        logic                            en;
        logic [LINES-1:0]                any;
        logic [LINES-1:0]                edg;
        logic [LINES-1:0]                pol;
        logic [LINES-1:0][IDX_W-1:0]     sel;
    } cfg_t;
endpackage

// File: rtl/girq_regs.sv
module girq_regs
    import girq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output cfg_t              cfg
);
    localparam int WORD_W = ADDR_W - 2;

    cfg_t               cfg_d, cfg_q;
    logic [WORD_W-1:0]  word;
    logic               aligned;

    assign word    = addr[ADDR_W-1:2];
    assign aligned = (addr[1:0] == 2'b00);

    always_comb begin
        cfg_d = cfg_q;
        rdata = '0;
        if (aligned && word == '0) begin
            rdata[EN_BIT]                  = cfg_q.en;
            rdata[ANY_LSB  +: LINES]       = cfg_q.any;
            rdata[EDGE_LSB +: LINES]       = cfg_q.edg;
            rdata[POL_LSB  +: LINES]       = cfg_q.pol;
            if (we) begin
                cfg_d.en  = wdata[EN_BIT];
                cfg_d.any = wdata[ANY_LSB  +: LINES];
                cfg_d.edg = wdata[EDGE_LSB +: LINES];
                cfg_d.pol = wdata[POL_LSB  +: LINES];
            end
        end
        for (int w = 0; w < SEL_WORDS; w++) begin
            if (aligned && word == WORD_W'(w + 1)) begin
                rdata[0       +: IDX_W] = cfg_q.sel[2*w];
                rdata[ODD_LSB +: IDX_W] = cfg_q.sel[2*w+1];
                if (we) begin
                    cfg_d.sel[2*w]   = wdata[0       +: IDX_W];
                    cfg_d.sel[2*w+1] = wdata[ODD_LSB +: IDX_W];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/girq_sync.sv
module girq_sync #(
    parameter int NUM_PINS = 62
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pins,
    output logic [NUM_PINS-1:0] cur,
    output logic [NUM_PINS-1:0] prv
);
    typedef struct packed {
        logic [NUM_PINS-1:0] meta;
        logic [NUM_PINS-1:0] now;
        logic [NUM_PINS-1:0] old;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = pins;
        st_d.now  = st_q.meta;
        st_d.old  = st_q.now;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur = st_q.now;
    assign prv = st_q.old;
endmodule

// File: rtl/girq_line.sv
module girq_line
    import girq_pkg::*;
#(
    parameter int NUM_PINS = 62
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                any,
    input  logic                edg,
    input  logic                pol,
    input  logic [IDX_W-1:0]    sel,
    input  logic [NUM_PINS-1:0] cur,
    input  logic [NUM_PINS-1:0] prv,
    output logic                irq
);
    localparam int                SPAN  = 2 ** IDX_W;
    localparam logic [IDX_W-1:0]  LIMIT = IDX_W'(NUM_PINS);

    typedef struct packed {
        logic irq;
    } line_t;

    line_t            st_d, st_q;
    logic [SPAN-1:0]  cur_x, prv_x;
    logic             valid, c, p, hit;

    assign cur_x = SPAN'(cur);
    assign prv_x = SPAN'(prv);

    always_comb begin
        valid = (sel < LIMIT);
        c     = cur_x[sel];
        p     = prv_x[sel];
        if (any)      hit = c ^ p;
        else if (edg) hit = pol ? (p & ~c) : (c & ~p);
        else          hit = c ^ pol;
        st_d.irq = en & valid & hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq = st_q.irq;
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
    import girq_pkg::*;
#(
    parameter int NUM_PINS = girq_pkg::PINS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pins_i,
    output logic [LINES-1:0]    irq_o
);
    cfg_t                cfg_w;
    logic [NUM_PINS-1:0] cur_w, prv_w;

    girq_regs regs_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bus_we),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .rdata (bus_rdata),
        .cfg   (cfg_w)
    );

    girq_sync #(.NUM_PINS(NUM_PINS)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .pins  (pins_i),
        .cur   (cur_w),
        .prv   (prv_w)
    );

    for (genvar n = 0; n < LINES; n++) begin : g_line
        girq_line #(.NUM_PINS(NUM_PINS)) line_i (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (cfg_w.en),
            .any   (cfg_w.any[n]),
            .edg   (cfg_w.edg[n]),
            .pol   (cfg_w.pol[n]),
            .sel   (cfg_w.sel[n]),
            .cur   (cur_w),
            .prv   (prv_w),
            .irq   (irq_o[n])
        );
    end
endmodule

// File: rtl/girq_chk.sv
module girq_chk
    import girq_pkg::*;
#(
    parameter int NUM_PINS = girq_pkg::PINS
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [LINES-1:0]  irq_o,
    input cfg_t              cfg
);
    localparam logic [IDX_W-1:0]    LIMIT   = IDX_W'(NUM_PINS);
    localparam logic [ADDR_W-3:0]   TOPWORD = (ADDR_W-2)'(SEL_WORDS);

    assert_disable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.en |=> (irq_o == '0));

    assert_clear_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == '0 && !bus_wdata[EN_BIT]) |-> ##2 (irq_o == '0));

    assert_unmapped_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[1:0] != 2'b00 || bus_addr[ADDR_W-1:2] > TOPWORD) |-> (bus_rdata == '0));

    assert_ctrl_rsvd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == '0) |-> (bus_rdata[30:24] == '0 && bus_rdata[EN_BIT] == cfg.en));

    assert_sel_rsvd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[1:0] == 2'b00 && bus_addr[ADDR_W-1:2] != '0 && bus_addr[ADDR_W-1:2] <= TOPWORD)
        |-> (bus_rdata[31:23] == '0 && bus_rdata[15:7] == '0));

    for (genvar n = 0; n < LINES; n++) begin : g_ln
        assert_undef_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg.sel[n] >= LIMIT) |=> !irq_o[n]);

        assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg.edg[n] && !cfg.any[n] && irq_o[n]) |=> !irq_o[n]);
    end
endmodule

bind gpio_irq_router girq_chk #(.NUM_PINS(NUM_PINS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .cfg       (cfg_w)
);

// File: tb/gpio_irq_router_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_router_tb_top;
    localparam int NP = 62;
    localparam int NL = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_we = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pins_i = '0;
    logic [NL-1:0] irq_o;

    int checks = 0;
    int errors = 0;
    bit cont_on = 1'b0;

    always #5 clk = ~clk;

    gpio_irq_router dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pins_i(pins_i), .irq_o(irq_o)
    );

    // reference model, built from the requirements
    logic          m_en;
    logic [7:0]    m_any, m_edg, m_pol;
    logic [6:0]    m_sel [NL];
    logic [NP-1:0] m_s1, m_s2, m_s3;
    logic [NL-1:0] m_irq;

    function automatic logic line_hit(input int n, input logic [NP-1:0] c_v,
                                      input logic [NP-1:0] p_v);
        logic c, p;
        if (!m_en || m_sel[n] >= 7'd62) return 1'b0;
        c = c_v[m_sel[n]];
        p = p_v[m_sel[n]];
        if (m_any[n]) return c != p;
        if (m_edg[n]) return m_pol[n] ? (p && !c) : (c && !p);
        return m_pol[n] ? !c : c;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en <= 1'b0; m_any <= '0; m_edg <= '0; m_pol <= '0;
            for (int i = 0; i < NL; i++) m_sel[i] <= '0;
            m_s1 <= '0; m_s2 <= '0; m_s3 <= '0; m_irq <= '0;
        end else begin
            m_s1 <= pins_i; m_s2 <= m_s1; m_s3 <= m_s2;
            for (int i = 0; i < NL; i++) m_irq[i] <= line_hit(i, m_s2, m_s3);
            if (bus_we && bus_addr[1:0] == 2'b00) begin
                if (bus_addr[7:2] == 6'd0) begin
                    m_en  <= bus_wdata[31];
                    m_any <= bus_wdata[23:16];
                    m_edg <= bus_wdata[15:8];
                    m_pol <= bus_wdata[7:0];
                end else if (bus_addr[7:2] <= 6'd4) begin
                    m_sel[2*(bus_addr[7:2]-1)]   <= bus_wdata[6:0];
                    m_sel[2*(bus_addr[7:2]-1)+1] <= bus_wdata[22:16];
                end
            end
        end
    end

    function automatic string tag_of(input int n);
        if (!m_en)            return "R10";
        if (m_sel[n] >= 7'd62) return "R9";
        if (m_any[n])         return "R8";
        if (m_edg[n])         return "R7";
        return "R6";
    endfunction

    // continuous comparison, away from the rising edge
    always @(negedge clk) begin
        if (cont_on) begin
            for (int i = 0; i < NL; i++) begin
                checks++;
                if (irq_o[i] !== m_irq[i]) begin
                    errors++;
                    $display("FAIL %s line %0d irq actual %b expected %b at %0t",
                             tag_of(i), i, irq_o[i], m_irq[i], $time);
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    logic [31:0] rv;

    initial begin
        #(10 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 irq", {24'd0, irq_o}, 32'd0);
        for (int a = 0; a <= 16; a += 4) begin
            rd(a[7:0], rv);
            chk("R1 reg", rv, 32'd0);
        end

        // R2: control word field layout and reserved bits
        wr(8'h00, 32'h7F5A_3CC3);
        rd(8'h00, rv);
        chk("R2 ctrl readback", rv, 32'h005A_3CC3);
        wr(8'h00, 32'h0000_0000);

        // R3: selector placement, even at 6:0 and odd at 22:16
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04, rv);
        chk("R3 sel mask", rv, 32'h007F_007F);
        wr(8'h0C, 32'h0025_0013);
        rd(8'h0C, rv);
        chk("R3 sel word2", rv, 32'h0025_0013);

        // R4: unmapped offsets
        wr(8'h14, 32'hFFFF_FFFF);
        wr(8'h06, 32'hFFFF_FFFF);
        rd(8'h14, rv); chk("R4 read 0x14", rv, 32'd0);
        rd(8'h06, rv); chk("R4 read 0x06", rv, 32'd0);
        rd(8'h04, rv); chk("R4 no side write 0x04", rv, 32'h007F_007F);
        rd(8'h00, rv); chk("R4 no side write ctrl", rv, 32'd0);
        rd(8'h08, rv); chk("R4 no side write 0x08", rv, 32'd0);

        // R5/R6: level latency on line 0 watching pin 5
        wr(8'h04, 32'h0000_0005);
        wr(8'h00, 32'h8000_0000);
        repeat (3) @(negedge clk);
        pins_i[5] = 1'b1;
        @(negedge clk); chk("R5 after edge k", {31'd0, irq_o[0]}, 32'd0);
        @(negedge clk); chk("R5 after edge k+1", {31'd0, irq_o[0]}, 32'd0);
        @(negedge clk); chk("R5 R6 after edge k+2", {31'd0, irq_o[0]}, 32'd1);

        // R9: undefined index with active-low level stays quiet
        wr(8'h08, 32'h0000_0064);
        wr(8'h00, 32'h8000_0004);
        repeat (4) @(negedge clk);
        chk("R9 idx 100 active-low", {31'd0, irq_o[2]}, 32'd0);

        // R7: falling edge on line 3 watching pin 40
        wr(8'h08, 32'h0028_0064);
        wr(8'h00, 32'h8000_0808);
        pins_i[40] = 1'b1;
        repeat (4) @(negedge clk);
        pins_i[40] = 1'b0;
        @(negedge clk); @(negedge clk);
        @(negedge clk); chk("R7 falling pulse", {31'd0, irq_o[3]}, 32'd1);
        @(negedge clk); chk("R7 pulse one cycle", {31'd0, irq_o[3]}, 32'd0);

        // R8: any-change on line 3 ignores its edge and polarity bits
        wr(8'h00, 32'h8008_0808);
        repeat (3) @(negedge clk);
        pins_i[40] = 1'b1;
        @(negedge clk); @(negedge clk);
        @(negedge clk); chk("R8 rise with pol=1", {31'd0, irq_o[3]}, 32'd1);

        // R10: clearing the enable silences a held level
        wr(8'h00, 32'h0000_0000);
        @(negedge clk);
        chk("R10 disabled", {24'd0, irq_o}, 32'd0);

        // random phase with colliding writes and pin changes
        cont_on = 1'b1;
        for (int it = 0; it < 4000; it++) begin
            @(negedge clk);
            bus_we = 1'b0;
            if ($urandom_range(0, 3) == 0) pins_i[$urandom_range(0, NP-1)] ^= 1'b1;
            if ($urandom_range(0, 2) == 0) pins_i[$urandom_range(0, 15)] ^= 1'b1;
            if ($urandom_range(0, 9) == 0) begin
                bus_we = 1'b1;
                case ($urandom_range(0, 6))
                    0: bus_addr = 8'h00;
                    1: bus_addr = 8'h04;
                    2: bus_addr = 8'h08;
                    3: bus_addr = 8'h0C;
                    4: bus_addr = 8'h10;
                    5: bus_addr = 8'h00;
                    default: bus_addr = 8'($urandom_range(0, 255));
                endcase
                bus_wdata = $urandom();
                if (bus_addr == 8'h00 && $urandom_range(0, 4) != 0) bus_wdata[31] = 1'b1;
                if (bus_addr != 8'h00 && $urandom_range(0, 1) == 0) begin
                    bus_wdata[6:0]   = 7'($urandom_range(0, 15));
                    bus_wdata[22:16] = 7'($urandom_range(0, 15));
                end
            end
        end
        @(negedge clk);
        bus_we = 1'b0;
        repeat (4) @(negedge clk);
        cont_on = 1'b0;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule